// File: doc/BRIEF.md
# Effective Address and Branch Target Unit

This unit sits between instruction decode and the memory/register stages of a 16-bit word-addressed core. It takes the current instruction word, the already incremented program counter, the value read from a base register and the three condition flags (negative, zero, positive). From these it produces one address: a data-memory address, a pointer address for the two-step indirect loads and stores, a value to load into a register, or a new program counter value. Qualifier outputs tell the consumer which of these the address is.

The opcode picks the base (incremented PC or base register) and the offset (a 9-bit or 6-bit signed field, or none). For conditional branches the unit compares the mask in the instruction with the flags. The load-effective-address case writes a register only and never reaches memory or the flags. The base-register index is decoded combinationally so the register file can return the base value in the same cycle. The address and its qualifiers pass through an output register that can be switched off by a parameter.

Top module: `addr_target_unit`

## Requirements
- R1: For opcodes 0010, 0011, 1010 and 1011, `addr` is `pc_inc` plus instruction bits [8:0] sign-extended, and `mem_req` is 1.
- R2: `indirect` is 1 only for opcodes 1010 and 1011, which mark `addr` as the location of a pointer to the operand.
- R3: For opcodes 0110 and 0111, `addr` is `base_val` plus instruction bits [5:0] sign-extended, and `mem_req` is 1.
- R4: For opcode 1100, `addr` equals `base_val` and `pc_load` is 1.
- R5: For opcode 1110, `addr` is `pc_inc` plus bits [8:0] sign-extended, `reg_load` is 1, and `mem_req` and `pc_load` are 0.
- R6: For opcode 0000, `addr` is `pc_inc` plus bits [8:0] sign-extended. `br_taken` and `pc_load` are 1 when instruction bits [11:9] share a set bit with `nzp`. Bit 11 and `nzp[2]` stand for negative, bit 10 and `nzp[1]` for zero, bit 9 and `nzp[0]` for positive.
- R7: A branch with mask 111 is taken whenever any flag is set. A branch with mask 000 is never taken, whatever the flags are.
- R8: Any other opcode (0001, 0100, 0101, 1000, 1001, 1101, 1111) gives `addr` 0, all qualifier outputs 0 and `base_idx` 0.
- R9: At most one of `mem_req`, `reg_load` and `pc_load` is 1 at any time.
- R10: With `REG_OUT`=1 (the default), `addr` and the qualifier outputs change one clock edge after their inputs change, and a synchronous active-high `rst` clears all of them to 0.
- R11: `base_idx` is combinational. It equals instruction bits [8:6] for opcodes 0110, 0111 and 1100, and 0 for every other opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| ir | input | 16 | Instruction word |
| pc_inc | input | 16 | Program counter after increment |
| base_val | input | 16 | Value read from the register named by `base_idx` |
| nzp | input | 3 | Condition flags {negative, zero, positive} |
| base_idx | output | 3 | Register index to read as base (combinational) |
| addr | output | 16 | Computed address or target |
| mem_req | output | 1 | Address is for a data memory access |
| indirect | output | 1 | Address points to the operand's address |
| reg_load | output | 1 | Address is written to a register (no memory, no flags) |
| pc_load | output | 1 | Address replaces the program counter |
| br_taken | output | 1 | Conditional branch condition met |

## Verification
A wrong base or offset choice shows up in `addr` one clock after the instruction is applied. Each addressing form is driven with a positive offset, a negative offset and a wraparound value, so a missing sign extension or a swapped offset field gives a wrong address at once. A broken decode shows up in the same cycle as a wrong qualifier combination or a nonzero `base_idx`. A broken mask comparison shows up in `br_taken` for a specific mask and flag pairing. Latency and reset faults are found by sampling `addr` just before the register edge, when it must still hold the previous result.

// File: rtl/atu_pkg.sv
package atu_pkg;

  localparam int unsigned IR_W  = 16;
  localparam int unsigned OP_W  = 4;
  localparam int unsigned FLG_W = 3;
  localparam int unsigned IDX_W = 3;

  typedef enum logic [2:0] {
    CL_NONE,
    CL_BR,
    CL_PCREL,
    CL_IND,
    CL_BASE,
    CL_JMP,
    CL_LEA
  } op_class_e;

  function automatic op_class_e classify(input logic [OP_W-1:0] op);
    case (op)
      4'b0000:          return CL_BR;
      4'b0010, 4'b0011: return CL_PCREL;
      4'b1010, 4'b1011: return CL_IND;
      4'b0110, 4'b0111: return CL_BASE;
      4'b1100:          return CL_JMP;
      4'b1110:          return CL_LEA;
      default:          return CL_NONE;
    endcase
  endfunction

  // mask bit and flag bit share position: [2]=neg [1]=zero [0]=pos
  function automatic logic cond_hit(input logic [FLG_W-1:0] mask,
                                    input logic [FLG_W-1:0] flags);
    return |(mask & flags);
  endfunction

endpackage

// File: rtl/atu_decode.sv
module atu_decode
  import atu_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output op_class_e       cls,
  output logic            sel_base,
  output logic            sel_off6,
  output logic            no_off,
  output logic            kill,
  output logic            mem_req,
  output logic            indirect,
  output logic            reg_load,
  output logic            is_br,
  output logic            is_jmp
);

  always_comb begin
    cls      = classify(op);
    sel_base = (cls == CL_BASE) || (cls == CL_JMP);
    sel_off6 = (cls == CL_BASE);
    no_off   = (cls == CL_JMP);
    kill     = (cls == CL_NONE);
    mem_req  = (cls == CL_PCREL) || (cls == CL_IND) || (cls == CL_BASE);
    indirect = (cls == CL_IND);
    reg_load = (cls == CL_LEA);
    is_br    = (cls == CL_BR);
    is_jmp   = (cls == CL_JMP);
  end

endmodule

// File: rtl/atu_cond.sv
module atu_cond
  import atu_pkg::*;
(
  input  logic             en,
  input  logic [FLG_W-1:0] mask,
  input  logic [FLG_W-1:0] flags,
  output logic             hit
);

  assign hit = en && cond_hit(mask, flags);

endmodule

// File: rtl/atu_adder.sv
module atu_adder #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] pc_inc,
  input  logic [DW-1:0] base_val,
  input  logic [8:0]    off9,
  input  logic [5:0]    off6,
  input  logic          sel_base,
  input  logic          sel_off6,
  input  logic          no_off,
  input  logic          kill,
  output logic [DW-1:0] sum
);

  localparam int unsigned EXT9 = DW - 9;
  localparam int unsigned EXT6 = DW - 6;

  logic [DW-1:0] base_sel;
  logic [DW-1:0] off_sel;

  always_comb begin
    base_sel = sel_base ? base_val : pc_inc;
    if (no_off)        off_sel = '0;
    else if (sel_off6) off_sel = {{EXT6{off6[5]}}, off6};
    else               off_sel = {{EXT9{off9[8]}}, off9};
    sum = kill ? '0 : (base_sel + off_sel);
  end

endmodule

// File: rtl/addr_target_unit.sv
module addr_target_unit
  import atu_pkg::*;
#(
  parameter int unsigned DW      = 16,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IR_W-1:0]  ir,
  input  logic [DW-1:0]    pc_inc,
  input  logic [DW-1:0]    base_val,
  input  logic [FLG_W-1:0] nzp,
  output logic [IDX_W-1:0] base_idx,
  output logic [DW-1:0]    addr,
  output logic             mem_req,
  output logic             indirect,
  output logic             reg_load,
  output logic             pc_load,
  output logic             br_taken
);

  op_class_e     cls;
  logic          sel_base, sel_off6, no_off, kill;
  logic          dec_mem, dec_ind, dec_reg, is_br, is_jmp;
  logic          nxt_br;
  logic [DW-1:0] nxt_addr;
  logic          nxt_mem, nxt_ind, nxt_reg, nxt_pc;

  atu_decode u_dec (
    .op       (ir[15:12]),
    .cls      (cls),
    .sel_base (sel_base),
    .sel_off6 (sel_off6),
    .no_off   (no_off),
    .kill     (kill),
    .mem_req  (dec_mem),
    .indirect (dec_ind),
    .reg_load (dec_reg),
    .is_br    (is_br),
    .is_jmp   (is_jmp)
  );

  atu_cond u_cond (
    .en    (is_br),
    .mask  (ir[11:9]),
    .flags (nzp),
    .hit   (nxt_br)
  );

  atu_adder #(.DW(DW)) u_add (
    .pc_inc   (pc_inc),
    .base_val (base_val),
    .off9     (ir[8:0]),
    .off6     (ir[5:0]),
    .sel_base (sel_base),
    .sel_off6 (sel_off6),
    .no_off   (no_off),
    .kill     (kill),
    .sum      (nxt_addr)
  );

  assign nxt_mem  = dec_mem;
  assign nxt_ind  = dec_ind;
  assign nxt_reg  = dec_reg;
  assign nxt_pc   = nxt_br || is_jmp;
  assign base_idx = sel_base ? ir[8:6] : '0;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          addr     <= '0;
          mem_req  <= 1'b0;
          indirect <= 1'b0;
          reg_load <= 1'b0;
          pc_load  <= 1'b0;
          br_taken <= 1'b0;
        end else begin
          addr     <= nxt_addr;
          mem_req  <= nxt_mem;
          indirect <= nxt_ind;
          reg_load <= nxt_reg;
          pc_load  <= nxt_pc;
          br_taken <= nxt_br;
        end
      end
    end else begin : g_comb
      assign addr     = nxt_addr;
      assign mem_req  = nxt_mem;
      assign indirect = nxt_ind;
      assign reg_load = nxt_reg;
      assign pc_load  = nxt_pc;
      assign br_taken = nxt_br;
    end
  endgenerate

endmodule

// File: rtl/atu_chk.sv
module atu_chk
  import atu_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [IR_W-1:0]  ir,
  input logic [DW-1:0]    pc_inc,
  input logic [DW-1:0]    base_val,
  input logic [FLG_W-1:0] nzp,
  input op_class_e        cls,
  input logic [IDX_W-1:0] base_idx,
  input logic [DW-1:0]    nxt_addr,
  input logic             nxt_mem,
  input logic             nxt_ind,
  input logic             nxt_reg,
  input logic             nxt_pc,
  input logic             nxt_br
);

  logic [3:0]    opc;
  logic [DW-1:0] pc_rel;
  assign opc    = ir[15:12];
  assign pc_rel = pc_inc + {{(DW-9){ir[8]}}, ir[8:0]};

  // R9
  excl_req_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({nxt_mem, nxt_reg, nxt_pc}));

  // R5
  lea_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == 4'b1110) |-> (nxt_reg && !nxt_mem && !nxt_pc && nxt_addr == pc_rel));

  // R4
  jmp_target_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == 4'b1100) |-> (nxt_pc && nxt_addr == base_val));

  // R7
  br_never_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == 4'b0000 && ir[11:9] == 3'b000) |-> !nxt_br);

  // R7
  br_always_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == 4'b0000 && ir[11:9] == 3'b111 && nzp != 3'b000) |-> (nxt_br && nxt_pc));

  // R8
  unsup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cls == CL_NONE) |-> (nxt_addr == '0 && !nxt_mem && !nxt_ind && !nxt_reg
                          && !nxt_pc && !nxt_br && base_idx == '0));

  // R2
  ind_mem_chk: assert property (@(posedge clk) disable iff (rst)
    nxt_ind |-> (nxt_mem && (opc == 4'b1010 || opc == 4'b1011)));

  // R11
  base_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (base_idx != '0) |-> (opc == 4'b0110 || opc == 4'b0111 || opc == 4'b1100));

endmodule

bind addr_target_unit atu_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ir       (ir),
  .pc_inc   (pc_inc),
  .base_val (base_val),
  .nzp      (nzp),
  .cls      (cls),
  .base_idx (base_idx),
  .nxt_addr (nxt_addr),
  .nxt_mem  (nxt_mem),
  .nxt_ind  (nxt_ind),
  .nxt_reg  (nxt_reg),
  .nxt_pc   (nxt_pc),
  .nxt_br   (nxt_br)
);

// File: tb/addr_target_unit_bench.sv
module addr_target_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;
  // {ir, pc_inc, base_val, nzp, exp_addr, exp {mem,ind,reg,pc,br}, exp_idx}
  localparam logic [74:0] VEC [NV] = '{
    {16'h2205, 16'h3000, 16'h0000, 3'b000, 16'h3005, 5'b10000, 3'd0}, // R1 LD +5
    {16'h35FE, 16'h3000, 16'h0000, 3'b000, 16'h2FFE, 5'b10000, 3'd0}, // R1 R11 ST -2
    {16'hA100, 16'h3000, 16'h0000, 3'b000, 16'h2F00, 5'b11000, 3'd0}, // R2 LDI -256
    {16'hBEFF, 16'h3000, 16'h0000, 3'b000, 16'h30FF, 5'b11000, 3'd0}, // R2 STI +255
    {16'h629F, 16'h3000, 16'h4000, 3'b000, 16'h401F, 5'b10000, 3'd2}, // R3 LDR +31
    {16'h7760, 16'h3000, 16'h0010, 3'b000, 16'hFFF0, 5'b10000, 3'd5}, // R3 STR -32
    {16'hC1C0, 16'h3000, 16'hABCD, 3'b000, 16'hABCD, 5'b00010, 3'd7}, // R4 JMP
    {16'hEA10, 16'h3000, 16'h0000, 3'b000, 16'h3010, 5'b00100, 3'd0}, // R5 LEA
    {16'h0804, 16'h3000, 16'h0000, 3'b100, 16'h3004, 5'b00011, 3'd0}, // R6 n taken
    {16'h05FC, 16'h3000, 16'h0000, 3'b001, 16'h2FFC, 5'b00000, 3'd0}, // R6 z not taken
    {16'h0E01, 16'h3000, 16'h0000, 3'b010, 16'h3001, 5'b00011, 3'd0}, // R7 mask 111
    {16'h0001, 16'h3000, 16'h0000, 3'b111, 16'h3001, 5'b00000, 3'd0}, // R7 mask 000
    {16'h1FFF, 16'h3000, 16'h1234, 3'b111, 16'h0000, 5'b00000, 3'd0}, // R8 op 0001
    {16'hF025, 16'h3000, 16'h1234, 3'b010, 16'h0000, 5'b00000, 3'd0}, // R8 op 1111
    {16'h9FFF, 16'h3000, 16'h1234, 3'b001, 16'h0000, 5'b00000, 3'd0}, // R8 op 1001
    {16'h0E02, 16'hFFFF, 16'h0000, 3'b001, 16'h0001, 5'b00011, 3'd0}, // R6 wrap
    {16'hE1FF, 16'h0000, 16'h0000, 3'b000, 16'hFFFF, 5'b00100, 3'd0}  // R5 wrap
  };
  localparam string TAG [NV] = '{"R1","R1","R2","R2","R3","R3","R4","R5","R6",
                                 "R6","R7","R7","R8","R8","R8","R6","R5"};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ir = '0, pc_inc = '0, base_val = '0;
  logic [2:0]  nzp = '0;
  logic [2:0]  base_idx;
  logic [15:0] addr;
  logic        mem_req, indirect, reg_load, pc_load, br_taken;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_target_unit u_addr_target_unit (
    .clk(clk), .rst(rst), .ir(ir), .pc_inc(pc_inc), .base_val(base_val),
    .nzp(nzp), .base_idx(base_idx), .addr(addr), .mem_req(mem_req),
    .indirect(indirect), .reg_load(reg_load), .pc_load(pc_load),
    .br_taken(br_taken)
  );

  function automatic logic [4:0] flags_now();
    return {mem_req, indirect, reg_load, pc_load, br_taken};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] prev_addr;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "reset addr", addr, 16'h0000);
    check("R10", "reset flags", {11'd0, flags_now()}, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    prev_addr = addr;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ir, pc_inc, base_val, nzp} = VEC[i][74:24];
      #1;
      // R11 combinational index
      check("R11", "base_idx", {13'd0, base_idx}, {13'd0, VEC[i][2:0]});
      // R10 output holds until the next edge
      check("R10", "addr before edge", addr, prev_addr);
      @(negedge clk);
      check(TAG[i], "addr", addr, VEC[i][23:8]);
      check(TAG[i], "flags", {11'd0, flags_now()}, {11'd0, VEC[i][7:3]});
      // R9 exclusive requests
      check("R9", "req count", 16'($countones({mem_req, reg_load, pc_load}) > 1), 16'd0);
      prev_addr = addr;
    end

    // R10 synchronous reset clears registered outputs during a live LEA
    @(negedge clk);
    ir = 16'hEA10; pc_inc = 16'h3000;
    @(negedge clk);
    check("R5", "lea reg_load", {15'd0, reg_load}, 16'd1);
    rst = 1'b1;
    @(negedge clk);
    check("R10", "reset clears addr", addr, 16'h0000);
    check("R10", "reset clears flags", {11'd0, flags_now()}, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    check("R10", "after reset addr", addr, 16'h3010);
    finish_run();
  end

endmodule